// File: doc/BRIEF.md
# Repeated-Character Burst Detector

This block watches a stream of received bytes for an escape burst. Such a burst is one configured character sent a programmed number of times in a row. It is bracketed by silence on both sides, as modems use to leave a data session. The block does not look only at byte values. It also times the stream in system clock cycles, and all three of the following must hold:

- The line must have been quiet long enough before the first character.
- Each gap between characters must stay short.
- The line must stay quiet long enough after the final character.

Only when all three hold does it raise a single-cycle detect pulse.

Bytes arrive on a valid/ready stream. The block is a pure sink that never stalls while enabled: `in_ready` follows `enable`. A byte is consumed on every cycle where both `in_valid` and `in_ready` are high. While `enable` is low, `in_ready` is low and any offered byte is left unconsumed and has no effect. All timing fields are counted as idle cycles. An idle cycle is a clock cycle in which no byte is consumed. Two bytes consumed on adjacent cycles are separated by zero idle cycles.

Top module: `burst_detect`

## Requirements
- R1: While reset is asserted or `enable` is low, `detect` is low, `in_ready` is low, and all progress toward a burst is discarded. Idle counting restarts from zero when `enable` rises.
- R2: `rep_count` consecutive bytes equal to `match_char`, each meeting the timing rules, produce a detection.
- R3: The first byte of a burst counts only if at least `lead_quiet` idle cycles preceded it, counted since the previous consumed byte or since `enable` rose. An exact match of `lead_quiet` qualifies.
- R4: Between two bytes of a burst there may be at most `gap_max` idle cycles. A longer gap breaks the burst.
- R5: A byte that differs from `match_char` breaks the burst in progress.
- R6: After the final byte of a burst is consumed at clock edge E, `detect` goes high on edge E + `tail_quiet` + 1, provided no byte was consumed in between.
- R7: Any byte consumed at or before the edge where `tail_quiet` idle cycles would be reached cancels the pending detection. This includes an extra copy of `match_char`.
- R8: A `rep_count` of zero never produces a detection.
- R9: `detect` is high for exactly one cycle per burst. Each detection requires at least one byte consumed since the previous one.
- R10: Dropping `enable` while a burst or its trailing quiet window is in progress cancels it.
- R11: Back-pressure: `in_ready` equals `enable`. A byte offered while `in_ready` is low is not consumed and cannot contribute to a detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Detector enable; low clears all state |
| match_char | input | 8 | Character the burst is made of |
| rep_count | input | 8 | Number of characters in a burst |
| gap_max | input | 24 | Largest allowed idle gap between burst characters |
| tail_quiet | input | 24 | Idle cycles required after the last character |
| lead_quiet | input | 24 | Idle cycles required before the first character |
| in_valid | input | 1 | Received byte offered |
| in_data | input | 8 | Received byte value |
| in_ready | output | 1 | Byte accepted this cycle when high with `in_valid` |
| detect | output | 1 | One-cycle pulse on a qualified burst |

## Verification
Some properties hold on every cycle, and the assertions check those:
- the pulse lasts one cycle (R9);
- a consumed byte always blocks a detect on the next edge (R7);
- nothing fires while disabled (R1, R10);
- each detection is preceded by fresh input (R9).

The rest depends on exact cycle counts and on history, and only the directed scenarios can show it:
- the boundaries of the lead, gap and tail windows, each tried at the limit and one cycle past it;
- breaks caused by a wrong character, an over-long burst or a zero count;
- the exact edge on which `detect` rises.

// File: rtl/burst_detect_pkg.sv
package burst_detect_pkg;

  typedef enum logic [1:0] {
    BST_HUNT = 2'd0,
    BST_RUN  = 2'd1,
    BST_TAIL = 2'd2
  } burst_state_e;

endpackage

// File: rtl/bd_quiet_timer.sv
// Counts idle cycles since the last consumed byte (or since enable rose)
// and compares the count against the three timing limits.
module bd_quiet_timer #(
  parameter int TIME_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              byte_take,
  input  logic [TIME_W-1:0] lead_limit,
  input  logic [TIME_W-1:0] gap_limit,
  input  logic [TIME_W-1:0] tail_limit,
  output logic              lead_ok,
  output logic              gap_ok,
  output logic              tail_ok
);
  localparam logic [TIME_W-1:0] SAT = {TIME_W{1'b1}};

  logic [TIME_W-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      quiet_q <= '0;
    end else if (byte_take) begin
      quiet_q <= '0;
    end else if (quiet_q != SAT) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  assign lead_ok = (quiet_q >= lead_limit);
  assign gap_ok  = (quiet_q <= gap_limit);
  assign tail_ok = (quiet_q >= tail_limit);

endmodule

// File: rtl/bd_burst_tracker.sv
// Tracks progress through a burst and flags the cycle in which the
// trailing quiet window completes.
module bd_burst_tracker
  import burst_detect_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              byte_take,
  input  logic [DATA_W-1:0] byte_val,
  input  logic [DATA_W-1:0] target,
  input  logic [CNT_W-1:0]  target_reps,
  input  logic              lead_ok,
  input  logic              gap_ok,
  input  logic              tail_ok,
  output logic              fire
);
  localparam logic [CNT_W:0] ONE_WIDE = {{CNT_W{1'b0}}, 1'b1};

  burst_state_e   state_q, state_d;
  logic [CNT_W:0] seen_q, seen_d;
  logic [CNT_W:0] seen_inc;
  logic [CNT_W:0] reps_wide;
  logic           is_match;
  logic           can_start;
  logic           can_extend;

  assign reps_wide  = {1'b0, target_reps};
  assign seen_inc   = seen_q + ONE_WIDE;
  assign is_match   = (byte_val == target);
  assign can_start  = is_match && lead_ok && (target_reps != '0);
  assign can_extend = (state_q == BST_RUN) && is_match && gap_ok;

  always_comb begin
    state_d = state_q;
    seen_d  = seen_q;
    fire    = 1'b0;
    if (byte_take) begin
      if (can_extend) begin
        seen_d  = seen_inc;
        state_d = (seen_inc >= reps_wide) ? BST_TAIL : BST_RUN;
      end else if (can_start) begin
        seen_d  = ONE_WIDE;
        state_d = (reps_wide == ONE_WIDE) ? BST_TAIL : BST_RUN;
      end else begin
        seen_d  = '0;
        state_d = BST_HUNT;
      end
    end else if (state_q == BST_TAIL && tail_ok) begin
      fire    = 1'b1;
      seen_d  = '0;
      state_d = BST_HUNT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state_q <= BST_HUNT;
      seen_q  <= '0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
    end
  end

endmodule

// File: rtl/burst_detect.sv
module burst_detect #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int TIME_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DATA_W-1:0] match_char,
  input  logic [CNT_W-1:0]  rep_count,
  input  logic [TIME_W-1:0] gap_max,
  input  logic [TIME_W-1:0] tail_quiet,
  input  logic [TIME_W-1:0] lead_quiet,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              detect
);
  logic byte_take;
  logic lead_ok, gap_ok, tail_ok;
  logic fire;
  logic detect_q;

  assign in_ready  = enable;
  assign byte_take = in_valid && in_ready;

  bd_quiet_timer #(.TIME_W(TIME_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .byte_take  (byte_take),
    .lead_limit (lead_quiet),
    .gap_limit  (gap_max),
    .tail_limit (tail_quiet),
    .lead_ok    (lead_ok),
    .gap_ok     (gap_ok),
    .tail_ok    (tail_ok)
  );

  bd_burst_tracker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .byte_take   (byte_take),
    .byte_val    (in_data),
    .target      (match_char),
    .target_reps (rep_count),
    .lead_ok     (lead_ok),
    .gap_ok      (gap_ok),
    .tail_ok     (tail_ok),
    .fire        (fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) detect_q <= 1'b0;
    else                   detect_q <= fire;
  end

  assign detect = detect_q;

endmodule

// File: rtl/burst_detect_checker.sv
module burst_detect_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic in_valid,
  input logic in_ready,
  input logic detect
);
  logic fresh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    fresh_q <= 1'b0;
    else if (in_valid && in_ready) fresh_q <= 1'b1;
    else if (detect)               fresh_q <= 1'b0;
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    detect |=> !detect);  // R9

  AST_BYTE_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !detect);  // R7

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !detect);  // R10

  AST_NEEDS_FRESH_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    detect |-> fresh_q);  // R9

endmodule

bind burst_detect burst_detect_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .detect   (detect)
);

// File: tb/burst_detect_test.sv
module burst_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  match_char = 8'h2B;
  logic [7:0]  rep_count = 8'd3;
  logic [23:0] gap_max = 24'd4;
  logic [23:0] tail_quiet = 24'd6;
  logic [23:0] lead_quiet = 24'd10;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        detect;

  int n_checks = 0;
  int n_fails = 0;
  int w_count;
  int w_first;

  always #2.5 clk = ~clk;

  burst_detect uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .match_char(match_char),
    .rep_count(rep_count), .gap_max(gap_max), .tail_quiet(tail_quiet),
    .lead_quiet(lead_quiet), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .detect(detect)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic burst(input int n, input int spacing, input logic [7:0] b);
    for (int i = 0; i < n; i++) begin
      if (i > 0) idle(spacing);
      send(b);
    end
  endtask

  task automatic watch(input int len);
    w_count = 0; w_first = -1;
    for (int i = 1; i <= len; i++) begin
      @(posedge clk); @(negedge clk);
      if (detect) begin
        w_count++;
        if (w_first < 0) w_first = i;
      end
    end
  endtask

  task automatic restart();
    enable = 1'b0;
    @(posedge clk); @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic defaults();
    match_char = 8'h2B; rep_count = 8'd3; gap_max = 24'd4;
    tail_quiet = 24'd6; lead_quiet = 24'd10;
  endtask

  task automatic t_reset();
    check(detect == 1'b0, "R1 detect in reset", detect, 0);
    check(in_ready == 1'b0, "R1 ready while disabled", in_ready, 0);
  endtask

  task automatic t_basic();
    defaults(); restart();
    check(in_ready == 1'b1, "R11 ready follows enable", in_ready, 1);
    idle(10); burst(3, 4, 8'h2B);   // lead exactly met (R3), gaps exactly gap_max (R4)
    watch(12);
    check(w_count == 1, "R2 one detection", w_count, 1);
    check(w_first == 7, "R6 detect edge", w_first, 7);
  endtask

  task automatic t_lead_short();
    defaults(); restart();
    idle(9); burst(3, 1, 8'h2B);
    watch(12);
    check(w_count == 0, "R3 lead quiet too short", w_count, 0);
  endtask

  task automatic t_gap_long();
    defaults(); restart();
    idle(10); burst(3, 5, 8'h2B);
    watch(12);
    check(w_count == 0, "R4 gap over limit", w_count, 0);
  endtask

  task automatic t_mismatch();
    defaults(); restart();
    idle(10); send(8'h2B); idle(1); send(8'h41); idle(1); burst(2, 1, 8'h2B);
    watch(12);
    check(w_count == 0, "R5 wrong char breaks", w_count, 0);
  endtask

  task automatic t_tail_cancel();
    defaults(); restart();
    idle(10); burst(3, 1, 8'h2B); idle(6); send(8'h61);
    watch(14);
    check(w_count == 0, "R7 byte at tail limit cancels", w_count, 0);
    restart(); idle(10); burst(4, 1, 8'h2B);
    watch(14);
    check(w_count == 0, "R7 extra pattern char cancels", w_count, 0);
  endtask

  task automatic t_single_zero_tail();
    defaults(); rep_count = 8'd1; tail_quiet = 24'd0; restart();
    idle(10); send(8'h2B);
    watch(4);
    check(w_count == 1, "R2 single char burst", w_count, 1);
    check(w_first == 1, "R6 zero tail edge", w_first, 1);
  endtask

  task automatic t_zero_count();
    defaults(); rep_count = 8'd0; restart();
    idle(10); burst(3, 1, 8'h2B);
    watch(12);
    check(w_count == 0, "R8 zero count silent", w_count, 0);
  endtask

  task automatic t_disable_mid();
    defaults(); restart();
    idle(10); burst(3, 1, 8'h2B); idle(2);
    restart();
    watch(12);
    check(w_count == 0, "R10 disable cancels tail", w_count, 0);
    idle(10); send(8'h2B); idle(1);
    restart(); idle(10); burst(2, 1, 8'h2B);
    watch(12);
    check(w_count == 0, "R10 disable discards progress", w_count, 0);
  endtask

  task automatic t_backpressure();
    defaults(); enable = 1'b0;
    idle(12);
    check(in_ready == 1'b0, "R11 ready low when disabled", in_ready, 0);
    burst(3, 1, 8'h2B);
    watch(12);
    check(w_count == 0, "R11 offered bytes ignored", w_count, 0);
    enable = 1'b1;
    burst(2, 1, 8'h2B);
    watch(12);
    check(w_count == 0, "R1 counting restarts on enable", w_count, 0);
  endtask

  task automatic t_back_to_back();
    defaults(); restart();
    idle(10); burst(3, 2, 8'h2B);
    watch(8);
    check(w_count == 1, "R9 first of pair", w_count, 1);
    idle(2); burst(3, 2, 8'h2B);
    watch(12);
    check(w_count == 1, "R9 second needs new burst", w_count, 1);
    check(w_first == 7, "R6 second detect edge", w_first, 7);
  endtask

  initial begin
    idle(4);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_basic();
    t_lead_short();
    t_gap_long();
    t_mismatch();
    t_tail_cancel();
    t_single_zero_tail();
    t_zero_count();
    t_disable_mid();
    t_backpressure();
    t_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule